// File: doc/BRIEF.md
# SPI Channel Transfer Controller

This block runs one channel of an SPI master. Software programs a channel configuration word, enables the channel and then exchanges data words through a transmit and a receive register on a small register bus. A shift engine moves each word out on MOSI and in from MISO, most significant bit first. The word length runs from 4 to 32 bits. SCLK runs at half the system clock and idles low. The chip select is active low and is asserted only while a word is shifting.

A transfer is only attempted when one of three things happens: the channel enable goes from 0 to 1, the transmit register is written, or the receive register is read. At that point the block checks three holds: the channel enable, a full receive holding register and an empty transmit holding register. A full receive register can be overridden by the turbo option. An empty transmit register is ignored in receive-only mode. When the module-level single-channel input is high and the force bit is clear, a transfer that is allowed finishes at once without shifting. When a transfer ends, the block sets the status flags, raises a one-cycle event strobe for the interrupt aggregator, and drives level DMA requests from the status and the DMA enable bits.

Top module: `spi_chan_ctrl`

## Requirements
- R1: After reset, configuration reads 0x060000, status reads 0x2 (only the transmit-empty flag, bit 1, set), control reads 0, and both DMA requests are low.
- R2: Writing the configuration stores only bits 22:0 (the other bits read 0). Writes to the status register (address 1) are ignored.
- R3: The word length is configuration bits 11:7 plus one. The word is shifted MSB first. MOSI changes while SCLK is low, MISO is sampled on the rising SCLK edge, and each bit takes two system clocks. cs_n is low for exactly 2×length cycles.
- R4: Configuration bits 13:12 select the mode: 1 is receive-only and 2 is transmit-only. In receive-only mode MOSI carries all zeros. In transmit-only mode the received word and the receive-full flag (status bit 0) are left unchanged.
- R5: A transfer attempt is made only on a channel-enable rising edge (control bit 0), a transmit write (address 3) or a receive read (address 4).
- R6: An attempt is dropped while the channel is disabled, while the receive-full flag is set (except in transmit-only mode), or while the transmit-empty flag is set (except in receive-only mode).
- R7: With configuration bit 19 (turbo) set, a set receive-full flag does not block an attempt, and no receive-full event is raised.
- R8: When input mod_single is 1 and configuration bit 20 (force) is 0, an allowed attempt completes in the next cycle. No shifting takes place, cs_n stays high and the received word is unchanged.
- R9: Completion sets end-of-transfer (status bit 2) and transmit-empty. It also sets receive-full and loads the received word, unless the mode is transmit-only. End-of-transfer stays set until reset.
- R10: A transmit write clears transmit-empty. A receive read returns the last received word and clears receive-full.
- R11: tx_dreq = enable AND config bit 14 AND transmit-empty AND mode≠1. rx_dreq = enable AND config bit 15 AND receive-full AND mode≠2.
- R12: evt_eot pulses for one cycle on every completion. evt_tx_empty pulses with it when the mode is not 1. evt_rx_full pulses with it when the mode is not 2 and turbo is clear. All three appear in the same cycle as the updated flags.
- R13: A transmit write or receive read in the same cycle as a completion wins over the completion for the flag it clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register select: 0 config, 1 status, 2 control, 3 transmit, 4 receive |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (has a side effect on address 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| mod_single | input | 1 | Module single-channel mode, gates shifting unless force is set |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low during a shift |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |
| evt_eot | output | 1 | End-of-transfer event strobe |
| evt_tx_empty | output | 1 | Transmit-empty event strobe |
| evt_rx_full | output | 1 | Receive-full event strobe |

## Verification
The case that needs care is a register access that lands in the same cycle as a completion. The completion sets a flag, and the access clears the same flag and also starts a new attempt. In single mode without force, a transfer completes in the cycle right after its trigger. This lets the bench place a receive read, or a second transmit write, exactly on the completion edge. The bench expects the access to win for the flag it clears. It also expects the retried attempt to be dropped by the flag the completion left set. A behavioural model steps these updates in the same order on every clock, so any mismatch in status, DMA requests or strobes is reported in the cycle where it appears.

// File: rtl/spi_chan_pkg.sv
package spi_chan_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = $clog2(WORD_W);
    localparam int CFG_W  = 23;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd2;
    localparam logic [ADDR_W-1:0] A_TX   = 3'd3;
    localparam logic [ADDR_W-1:0] A_RX   = 3'd4;

    typedef enum logic [1:0] {
        XM_DUPLEX  = 2'd0,
        XM_RX_ONLY = 2'd1,
        XM_TX_ONLY = 2'd2,
        XM_BAD     = 2'd3
    } xfer_mode_e;

    // field positions are part of the register interface
    typedef struct packed {
        logic [1:0]  rsv_hi;    // 22:21
        logic        force_sh;  // 20
        logic        turbo;     // 19
        logic [2:0]  rsv_mid;   // 18:16
        logic        dma_rx;    // 15
        logic        dma_tx;    // 14
        xfer_mode_e  mode;      // 13:12
        logic [4:0]  wl;        // 11:7
        logic [6:0]  rsv_lo;    // 6:0
    } chan_cfg_t;

    typedef struct packed {
        logic eot;   // bit 2
        logic txs;   // bit 1
        logic rxs;   // bit 0
    } chan_stat_t;

    localparam logic [CFG_W-1:0] CFG_RST = 23'h060000;

    function automatic logic mode_uses_tx(xfer_mode_e m);
        return m != XM_RX_ONLY;
    endfunction

    function automatic logic mode_uses_rx(xfer_mode_e m);
        return m != XM_TX_ONLY;
    endfunction

    function automatic logic attempt_ok(logic en, chan_stat_t st, chan_cfg_t c);
        logic rx_hold;
        logic tx_hold;
        rx_hold = st.rxs && mode_uses_rx(c.mode) && !c.turbo;
        tx_hold = st.txs && mode_uses_tx(c.mode);
        return en && !rx_hold && !tx_hold;
    endfunction

endpackage

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_chan_pkg::*;
#(
    parameter int W   = WORD_W,
    parameter int LW  = LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [LW-1:0] last_bit,
    input  logic [W-1:0]  tx_word,
    input  logic          miso,
    output logic          busy,
    output logic          done,
    output logic [W-1:0]  rx_word,
    output logic          sclk,
    output logic          mosi,
    output logic          cs_n
);

    logic          busy_q, done_q, sclk_q;
    logic [LW-1:0] idx_q;
    logic [W-1:0]  tx_q, rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            sclk_q <= 1'b0;
            idx_q  <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                busy_q <= 1'b1;
                sclk_q <= 1'b0;
                idx_q  <= last_bit;
                tx_q   <= tx_word;
                rx_q   <= '0;
            end else if (busy_q) begin
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_q   <= {rx_q[W-2:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    if (idx_q == '0) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        idx_q <= idx_q - 1'b1;
                    end
                end
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign rx_word = rx_q;
    assign sclk    = sclk_q;
    assign cs_n    = !busy_q;
    assign mosi    = busy_q ? tx_q[idx_q] : 1'b0;

    p_cs_sclk_r3: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);
    p_sclk_toggle_r3: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && $past(!cs_n)) |-> (sclk != $past(sclk)));
    p_cs_from_start_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> $past(start));

endmodule

// File: rtl/spi_chan_regs.sv
module spi_chan_regs
    import spi_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic              mod_single,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic [WORD_W-1:0] eng_rx,
    output logic              start,
    output logic [LEN_W-1:0]  start_last,
    output logic [WORD_W-1:0] start_word,
    output logic              tx_dreq,
    output logic              rx_dreq,
    output logic              evt_eot,
    output logic              evt_tx_empty,
    output logic              evt_rx_full
);

    chan_cfg_t         cfg_q;
    chan_stat_t        st_q;
    logic              en_q, pend_q;
    logic [WORD_W-1:0] txw_q, rxw_q;
    logic              ev_eot_q, ev_txe_q, ev_rxf_q;

    logic wr_cfg, wr_ctrl, wr_tx, rd_rx, trig, idle, go, shift_ok, complete;

    assign wr_cfg   = wr && (addr == A_CFG);
    assign wr_ctrl  = wr && (addr == A_CTRL);
    assign wr_tx    = wr && (addr == A_TX);
    assign rd_rx    = rd && (addr == A_RX);
    assign trig     = wr_tx || rd_rx || (wr_ctrl && wdata[0] && !en_q);
    assign idle     = !eng_busy && !eng_done;
    assign go       = pend_q && idle && attempt_ok(en_q, st_q, cfg_q);
    assign shift_ok = !mod_single || cfg_q.force_sh;
    assign complete = eng_done || (go && !shift_ok);

    assign start      = go && shift_ok;
    assign start_last = cfg_q.wl;
    assign start_word = mode_uses_tx(cfg_q.mode) ? txw_q : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= chan_cfg_t'(CFG_RST);
            st_q     <= '{eot: 1'b0, txs: 1'b1, rxs: 1'b0};
            en_q     <= 1'b0;
            pend_q   <= 1'b0;
            txw_q    <= '0;
            rxw_q    <= '0;
            ev_eot_q <= 1'b0;
            ev_txe_q <= 1'b0;
            ev_rxf_q <= 1'b0;
        end else begin
            ev_eot_q <= complete;
            ev_txe_q <= complete && mode_uses_tx(cfg_q.mode);
            ev_rxf_q <= complete && mode_uses_rx(cfg_q.mode) && !cfg_q.turbo;
            // completion first; a same-cycle access below overrides it
            if (complete) begin
                st_q.eot <= 1'b1;
                st_q.txs <= 1'b1;
                if (mode_uses_rx(cfg_q.mode)) begin
                    st_q.rxs <= 1'b1;
                    if (eng_done) rxw_q <= eng_rx;
                end
            end
            if (wr_cfg)  cfg_q <= chan_cfg_t'(wdata[CFG_W-1:0]);
            if (wr_ctrl) en_q  <= wdata[0];
            if (wr_tx) begin
                txw_q    <= wdata;
                st_q.txs <= 1'b0;
            end
            if (rd_rx) st_q.rxs <= 1'b0;
            pend_q <= trig || (pend_q && !idle);
        end
    end

    always_comb begin
        case (addr)
            A_CFG:   rdata = {{(WORD_W-CFG_W){1'b0}}, cfg_q};
            A_STAT:  rdata = {{(WORD_W-3){1'b0}}, st_q};
            A_CTRL:  rdata = {{(WORD_W-1){1'b0}}, en_q};
            A_TX:    rdata = txw_q;
            A_RX:    rdata = rxw_q;
            default: rdata = '0;
        endcase
    end

    assign tx_dreq = en_q && cfg_q.dma_tx && st_q.txs && mode_uses_tx(cfg_q.mode);
    assign rx_dreq = en_q && cfg_q.dma_rx && st_q.rxs && mode_uses_rx(cfg_q.mode);

    assign evt_eot      = ev_eot_q;
    assign evt_tx_empty = ev_txe_q;
    assign evt_rx_full  = ev_rxf_q;

    p_busy_no_start_r6: assert property (@(posedge clk) disable iff (rst)
        eng_busy |-> !start);
    p_done_sets_eot_r9: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> st_q.eot);
    p_txs_clear_r10: assert property (@(posedge clk) disable iff (rst)
        wr_tx |=> !st_q.txs);
    p_rxs_clear_r10: assert property (@(posedge clk) disable iff (rst)
        rd_rx |=> !st_q.rxs);
    p_evt_with_eot_r12: assert property (@(posedge clk) disable iff (rst)
        evt_eot |-> st_q.eot);

endmodule

// File: rtl/spi_chan_ctrl.sv
module spi_chan_ctrl
    import spi_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              mod_single,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n,
    output logic              tx_dreq,
    output logic              rx_dreq,
    output logic              evt_eot,
    output logic              evt_tx_empty,
    output logic              evt_rx_full
);

    logic              eng_busy, eng_done, eng_start;
    logic [WORD_W-1:0] eng_rx, eng_tx;
    logic [LEN_W-1:0]  eng_last;

    spi_chan_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .addr         (reg_addr),
        .wr           (reg_wr),
        .rd           (reg_rd),
        .wdata        (reg_wdata),
        .rdata        (reg_rdata),
        .mod_single   (mod_single),
        .eng_busy     (eng_busy),
        .eng_done     (eng_done),
        .eng_rx       (eng_rx),
        .start        (eng_start),
        .start_last   (eng_last),
        .start_word   (eng_tx),
        .tx_dreq      (tx_dreq),
        .rx_dreq      (rx_dreq),
        .evt_eot      (evt_eot),
        .evt_tx_empty (evt_tx_empty),
        .evt_rx_full  (evt_rx_full)
    );

    spi_shift_engine #(.W(WORD_W), .LW(LEN_W)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .start    (eng_start),
        .last_bit (eng_last),
        .tx_word  (eng_tx),
        .miso     (miso),
        .busy     (eng_busy),
        .done     (eng_done),
        .rx_word  (eng_rx),
        .sclk     (sclk),
        .mosi     (mosi),
        .cs_n     (cs_n)
    );

endmodule

// File: tb/spi_chan_ctrl_tb_top.sv
`timescale 1ns/100ps
module spi_chan_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_addr = 3'd1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mod_single = 1'b0;
    logic        sclk, mosi, cs_n, tx_dreq, rx_dreq;
    logic        evt_eot, evt_tx_empty, evt_rx_full;
    logic        miso;

    always #2.5 clk = ~clk;

    spi_chan_ctrl dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mod_single(mod_single),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n),
        .tx_dreq(tx_dreq), .rx_dreq(rx_dreq),
        .evt_eot(evt_eot), .evt_tx_empty(evt_tx_empty), .evt_rx_full(evt_rx_full)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- slave device model ----------------
    logic [31:0] sw = '0;     // word the slave returns
    int          s_n = 8;     // word length the test programs
    int          sidx = -1;
    logic [31:0] cap = '0;    // bits seen on MOSI
    assign miso = (sidx >= 0) ? sw[sidx] : 1'b0;
    always @(negedge cs_n) sidx = s_n - 1;
    always @(negedge sclk) if (sidx >= 0) sidx = sidx - 1;
    always @(posedge sclk) cap = {cap[30:0], mosi};

    // ---------------- behavioural reference ----------------
    logic [31:0] m_cfg, m_txw, m_rxw, m_mosi;
    bit  m_en, m_txs, m_rxs, m_eot, m_pend;
    bit  e_eot, e_txe, e_rxf;
    int  m_cnt, m_n;
    int  md;
    bit  tb_ok, idl, comp, shifted, trig;

    function automatic logic [31:0] lowmask(int n);
        logic [63:0] one = 64'd1;
        return 32'((one << n) - 64'd1);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cfg = 32'h060000; m_en = 0; m_txs = 1; m_rxs = 0; m_eot = 0;
            m_txw = 0; m_rxw = 0; m_pend = 0; m_cnt = 0; m_n = 0; m_mosi = 0;
            e_eot = 0; e_txe = 0; e_rxf = 0;
        end else begin
            md = (m_cfg >> 12) & 3;
            idl = (m_cnt == 0);
            comp = 0; shifted = 0; trig = 0;
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin comp = 1; shifted = 1; end
            end
            tb_ok = m_en && !(m_rxs && md != 2 && !m_cfg[19]) && !(m_txs && md != 1);
            if (m_pend && idl && tb_ok) begin
                if (!mod_single || m_cfg[20]) begin
                    m_n = ((m_cfg >> 7) & 31) + 1;
                    m_cnt = 2 * m_n + 1;
                    m_mosi = (md == 1) ? 0 : (m_txw & lowmask(m_n));
                end else comp = 1;
            end
            e_eot = comp;
            e_txe = comp && md != 1;
            e_rxf = comp && md != 2 && !m_cfg[19];
            if (comp) begin
                m_eot = 1; m_txs = 1;
                if (md != 2) begin
                    m_rxs = 1;
                    if (shifted) m_rxw = sw & lowmask(m_n);
                end
            end
            if (reg_wr) begin
                if (reg_addr == 0) m_cfg = reg_wdata & 32'h7fffff;
                if (reg_addr == 2) begin
                    if (reg_wdata[0] && !m_en) trig = 1;
                    m_en = reg_wdata[0];
                end
                if (reg_addr == 3) begin m_txw = reg_wdata; m_txs = 0; trig = 1; end
            end
            if (reg_rd && reg_addr == 4) begin m_rxs = 0; trig = 1; end
            m_pend = trig || (m_pend && !idl);
        end
    end

    function automatic logic [31:0] exp_rdata(logic [2:0] a);
        case (a)
            3'd0: return m_cfg;
            3'd1: return {29'd0, m_eot, m_txs, m_rxs};
            3'd2: return {31'd0, m_en};
            3'd3: return m_txw;
            3'd4: return m_rxw;
            default: return 0;
        endcase
    endfunction

    int cs_low = 0, n_eot = 0, n_txe = 0, n_rxf = 0;
    int md2;

    // every-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst) begin
            md2 = (m_cfg >> 12) & 3;
            check("R9/R10 register read", reg_rdata, exp_rdata(reg_addr));
            check("R11 tx_dreq", 32'(tx_dreq), 32'(m_en && m_cfg[14] && m_txs && md2 != 1));
            check("R11 rx_dreq", 32'(rx_dreq), 32'(m_en && m_cfg[15] && m_rxs && md2 != 2));
            check("R12 evt_eot", 32'(evt_eot), 32'(e_eot));
            check("R12 evt_tx_empty", 32'(evt_tx_empty), 32'(e_txe));
            check("R12 evt_rx_full", 32'(evt_rx_full), 32'(e_rxf));
            check("R3 cs_n", 32'(cs_n), 32'(!(m_cnt >= 2)));
            if (!cs_n) cs_low++;
            if (evt_eot) n_eot++;
            if (evt_tx_empty) n_txe++;
            if (evt_rx_full) n_rxf++;
        end
    end

    // ---------------- drive tasks ----------------
    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic do_wr(logic [2:0] a, logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        cyc();
        reg_wr = 1'b0; reg_addr = 3'd1;
    endtask

    task automatic do_rd(logic [2:0] a, output logic [31:0] d);
        reg_addr = a; reg_rd = 1'b1; #0.5;
        d = reg_rdata;
        cyc();
        reg_rd = 1'b0; reg_addr = 3'd1;
    endtask

    task automatic peek(logic [2:0] a, output logic [31:0] d);
        reg_addr = a; #0.5;
        d = reg_rdata;
        reg_addr = 3'd1;
    endtask

    task automatic settle();
        do cyc(); while (m_cnt != 0 || m_pend);
        cyc(); cyc();
    endtask

    task automatic clr_counts();
        cs_low = 0; n_eot = 0; n_txe = 0; n_rxf = 0; cap = 0;
    endtask

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    localparam logic [31:0] DMA2 = 32'h0000_C000;
    logic [31:0] v;

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        // R1 reset state
        peek(3'd0, v); check("R1 config reset", v, 32'h060000);
        peek(3'd1, v); check("R1 status reset", v, 32'h2);
        peek(3'd2, v); check("R1 control reset", v, 32'h0);
        check("R1 dreqs reset", {30'd0, tx_dreq, rx_dreq}, 0);
        // R2 write mask, status ignored
        do_wr(3'd0, 32'hFFFF_FFFF);
        peek(3'd0, v); check("R2 config mask", v, 32'h7FFFFF);
        do_wr(3'd1, 32'h0);
        peek(3'd1, v); check("R2 status write ignored", v, 32'h2);

        // 8-bit duplex
        do_wr(3'd0, DMA2 | (7 << 7)); s_n = 8;
        do_wr(3'd2, 1);
        check("R11 tx_dreq after enable", 32'(tx_dreq), 1);
        sw = 32'hA5; clr_counts();
        do_wr(3'd3, 32'h3C); settle();
        check("R3 mosi 8b", cap & 32'hFF, 32'h3C);
        check("R3 cs low 8b", cs_low, 16);
        peek(3'd1, v); check("R9 status after", v, 32'h7);
        check("R12 eot count", n_eot, 1);
        check("R12 txe count", n_txe, 1);
        check("R12 rxf count", n_rxf, 1);
        do_rd(3'd4, v); check("R10 rx word 8b", v, 32'hA5);
        peek(3'd1, v); check("R10 rxs cleared", v, 32'h6);

        // 16-bit
        do_wr(3'd0, DMA2 | (15 << 7)); s_n = 16; sw = 32'h1234; clr_counts();
        do_wr(3'd3, 32'hBEEF); settle();
        check("R3 mosi 16b", cap & 32'hFFFF, 32'hBEEF);
        do_rd(3'd4, v); check("R3 rx 16b", v, 32'h1234);

        // 32-bit
        do_wr(3'd0, DMA2 | (31 << 7)); s_n = 32; sw = 32'h89AB_CDEF; clr_counts();
        do_wr(3'd3, 32'h1357_9BDF); settle();
        check("R3 mosi 32b", cap, 32'h1357_9BDF);
        check("R3 cs low 32b", cs_low, 64);

        // R6 blocked by full receive register
        clr_counts();
        do_wr(3'd3, 32'h55); settle();
        check("R6 blocked by rxs", cs_low, 0);
        peek(3'd1, v); check("R6 status while blocked", v, 32'h5);
        // R5 receive read retries
        sw = 32'h0F0F_0F0F;
        do_rd(3'd4, v); check("R10 rx 32b", v, 32'h89AB_CDEF);
        settle();
        check("R5 read retry runs", cs_low, 64);
        peek(3'd4, v); check("R5 rx after retry", v, 32'h0F0F_0F0F);

        // R7 turbo
        do_wr(3'd0, DMA2 | (31 << 7) | (1 << 19)); clr_counts();
        do_wr(3'd3, 32'h1); settle();
        check("R7 turbo runs with rxs", cs_low, 64);
        check("R7 no rx_full event", n_rxf, 0);
        check("R12 txe under turbo", n_txe, 1);

        // R4 receive-only
        do_wr(3'd0, DMA2 | (7 << 7) | (1 << 12)); s_n = 8; sw = 32'h6C;
        check("R11 tx_dreq off rx-only", 32'(tx_dreq), 0);
        clr_counts(); cap = 32'hFFFF_FFFF;
        do_rd(3'd4, v); settle();
        check("R4 mosi zeros", cap & 32'hFF, 0);
        peek(3'd4, v); check("R4 rx-only word", v, 32'h6C);

        // R4 transmit-only
        do_wr(3'd0, DMA2 | (7 << 7) | (2 << 12)); sw = 32'hFF; clr_counts();
        check("R11 rx_dreq off tx-only", 32'(rx_dreq), 0);
        do_wr(3'd3, 32'h81); settle();
        check("R4 tx-only shifted", cap & 32'hFF, 32'h81);
        peek(3'd4, v); check("R4 tx-only rx kept", v, 32'h6C);
        peek(3'd1, v); check("R4 tx-only rxs kept", v, 32'h7);

        // R8 single mode without force
        mod_single = 1'b1;
        do_wr(3'd0, DMA2 | (7 << 7));
        do_rd(3'd4, v);
        sw = 32'h99; clr_counts();
        do_wr(3'd3, 32'h42); settle();
        check("R8 no shift", cs_low, 0);
        check("R8 completes", n_eot, 1);
        peek(3'd4, v); check("R8 rx unchanged", v, 32'h6C);
        // with force it shifts
        do_wr(3'd0, DMA2 | (7 << 7) | (1 << 20));
        do_rd(3'd4, v); clr_counts();
        do_wr(3'd3, 32'h42); settle();
        check("R8 force shifts", cs_low, 16);
        peek(3'd4, v); check("R8 force rx", v, 32'h99);
        mod_single = 1'b0;

        // R5 / R6 enable gating
        do_wr(3'd2, 0);
        do_rd(3'd4, v); sw = 32'h11; clr_counts();
        do_wr(3'd3, 32'h77); settle();
        check("R6 disabled no shift", cs_low, 0);
        do_wr(3'd2, 1); settle();
        check("R5 enable edge runs", cs_low, 16);
        peek(3'd4, v); check("R5 rx after enable", v, 32'h11);

        // R13 same-cycle access versus completion
        mod_single = 1'b1;
        do_wr(3'd0, DMA2 | (7 << 7));
        do_rd(3'd4, v); settle();
        do_wr(3'd3, 32'h5A);
        do_rd(3'd4, v); settle();
        peek(3'd1, v); check("R13 read beats completion", v, 32'h6);
        do_wr(3'd3, 32'h5B);
        do_wr(3'd3, 32'h5C); settle();
        peek(3'd1, v); check("R13 write beats completion", v, 32'h5);
        mod_single = 1'b0;

        repeat (4) cyc();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule